// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs one DMA channel. Software sets a transfer count, a destination base address, a fixed source address, a byte or word transfer size and two mode selections, then pulses `start_i`. The sequencer waits for a trigger and asks for the bus. Once it is granted the bus, it reads one unit from the source address and writes that unit to the current destination address. After each write completes, it steps the destination address. When the count runs out, the channel switches itself off and raises a one-cycle completion pulse.

There are four trigger sources. The first is a falling edge on an active-low request pin. Each synchronized edge queues one transfer, and an edge that arrives during a transfer is kept. The second is the same pin held low. The pin is sampled again after every transfer. The third is a free-running automatic request that gives the bus back after every transfer. The fourth is an automatic request that keeps the bus until the whole count is moved. Each destination step is +1 or +2 for a byte or word transfer, or −1 or −2, or zero, depending on a direction bit and a step-enable bit. The address wraps modulo 2^24.

Top module: `dma_xfer_seq`

## Requirements
- R1: A `start_i` pulse while the channel is inactive and `xfer_cnt_i` is nonzero loads the count, the destination base, the source address, the size and both mode selections, and sets `active_o`. A start with a zero count, or a start while active, has no effect.
- R2: Destination stepping uses `dst_step_en_i` and `dst_dir_i`. With the enable at 0 the address is held, whatever the direction. With the enable at 1, direction 0 increments the address and direction 1 decrements it. The latched copies of these bits reset to 0, which holds the address.
- R3: The step is 1 when `size_word_i` is 0 and 2 when it is 1. The arithmetic wraps modulo 2^24. The address changes only after the write of a transfer has completed.
- R4: Each transfer reads from the latched source address and then writes the data it read to the current destination address. `mem_we_o` is 0 for the read and 1 for the write.
- R5: With `act_mode_i` = 2'b00, each falling edge of `dreq_n_i` starts one transfer after a two-flop synchronizer. An edge seen during a transfer is held until that transfer finishes. With no edge, no transfer starts.
- R6: With `act_mode_i` = 2'b01, transfers repeat while the synchronized `dreq_n_i` is low, and they stop once it is seen high. The channel stays active.
- R7: With `act_mode_i` = 2'b10, transfers request themselves, and `bus_req_o` goes low for at least one cycle after every transfer.
- R8: With `act_mode_i` = 2'b11, transfers request themselves, and `bus_req_o` stays high without a break from the first request until the last transfer ends.
- R9: A 16-bit count drops by one per transfer. When it reaches zero, `active_o` clears and `done_o` is high for exactly one cycle.
- R10: After reset, `bus_req_o`, `mem_req_o`, `active_o`, `done_o` and `dst_addr_o` are all 0.
- R11: `mem_req_o` is asserted only while `bus_req_o` is high and `bus_gnt_i` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that loads the setup and enables the channel |
| xfer_cnt_i | input | 16 | Number of transfers to perform |
| size_word_i | input | 1 | 0 selects byte transfers, 1 selects word transfers |
| act_mode_i | input | 2 | Trigger: 00 pin edge, 01 pin level, 10 auto with bus release, 11 auto burst |
| dst_dir_i | input | 1 | Destination direction: 0 up, 1 down |
| dst_step_en_i | input | 1 | Destination stepping enable |
| dst_base_i | input | 24 | Destination start address |
| src_addr_i | input | 24 | Fixed source address |
| dreq_n_i | input | 1 | Asynchronous active-low external request |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus grant |
| mem_req_o | output | 1 | Memory access strobe, held until acknowledged |
| mem_we_o | output | 1 | 1 marks a write |
| mem_addr_o | output | 24 | Memory access address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid along with the acknowledge |
| mem_ack_i | input | 1 | One-cycle access acknowledge |
| dst_addr_o | output | 24 | Current destination address |
| active_o | output | 1 | Channel enabled |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on three properties of the environment. The bus grant stays high for as long as `bus_req_o` is held once it has been given. `mem_ack_i` arrives only for an access that is pending. `start_i` is not pulsed while the channel is busy, unless the test is checking that such a pulse is ignored. The bench models the grant as `bus_req_o` delayed by one register, and the memory acknowledges one cycle after each strobe. This keeps the grant stable through every access and limits each acknowledge to a single cycle. The request pin is changed only on falling clock edges, and each level is held for at least two cycles, so every edge passes through the synchronizer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic [1:0] {
      ACT_EDGE  = 2'b00,
      ACT_LEVEL = 2'b01,
      ACT_STEAL = 2'b10,
      ACT_BURST = 2'b11
   } act_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_ARB,
      ST_RD,
      ST_WR,
      ST_POST
   } seq_state_e;
endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect
   import dma_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk_i,
   input  logic      rst_n_i,
   input  logic      dreq_n_i,
   input  act_mode_e mode_i,
   input  logic      arm_i,
   input  logic      clear_i,
   input  logic      take_i,
   output logic      req_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dma_req_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pend_q;
   logic                   pin_s;
   logic                   fall;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) sync_q[0] <= 1'b1;
            else          sync_q[0] <= dreq_n_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) sync_q[i] <= 1'b1;
            else          sync_q[i] <= sync_q[i-1];
         end
      end
   end

   assign pin_s = sync_q[SYNC_STAGES-1];
   assign fall  = prev_q & ~pin_s;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         prev_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin_s;
         if (clear_i)
            pend_q <= 1'b0;
         else if (fall && arm_i && mode_i == ACT_EDGE)
            pend_q <= 1'b1;
         else if (take_i)
            pend_q <= 1'b0;
      end
   end

   always_comb begin
      case (mode_i)
         ACT_EDGE:  req_o = pend_q;
         ACT_LEVEL: req_o = ~pin_s;
         default:   req_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int AW        = 24,
   parameter int WORD_STEP = 2
) (
   input  logic [AW-1:0] addr_i,
   input  logic          size_word_i,
   input  logic          dir_i,
   input  logic          step_en_i,
   output logic [AW-1:0] next_o
);
   generate
      if (WORD_STEP < 1) begin : g_bad_step
         $error("dma_addr_step: WORD_STEP must be positive");
      end
   endgenerate

   localparam logic [AW-1:0] STEP_B = AW'(1);
   localparam logic [AW-1:0] STEP_W = AW'(WORD_STEP);

   logic [AW-1:0] step;

   always_comb begin
      step = size_word_i ? STEP_W : STEP_B;
      if (!step_en_i)
         next_o = addr_i;
      else if (dir_i)
         next_o = addr_i - step;
      else
         next_o = addr_i + step;
   end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
   import dma_seq_pkg::*;
(
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic active_i,
   input  logic req_i,
   input  logic burst_i,
   input  logic last_i,
   input  logic bus_gnt_i,
   input  logic mem_ack_i,
   output logic bus_req_o,
   output logic mem_req_o,
   output logic mem_we_o,
   output logic take_o,
   output logic rd_done_o,
   output logic wr_done_o,
   output logic post_o
);
   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (active_i)  state_d = ST_WAIT;
         ST_WAIT: if (req_i)     state_d = ST_ARB;
         ST_ARB:  if (bus_gnt_i) state_d = ST_RD;
         ST_RD:   if (mem_ack_i) state_d = ST_WR;
         ST_WR:   if (mem_ack_i) state_d = ST_POST;
         ST_POST: begin
            if (last_i)       state_d = ST_IDLE;
            else if (burst_i) state_d = ST_RD;
            else              state_d = ST_WAIT;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) state_q <= ST_IDLE;
      else          state_q <= state_d;
   end

   assign bus_req_o = (state_q == ST_ARB) || (state_q == ST_RD) ||
                      (state_q == ST_WR)  || (state_q == ST_POST);
   assign mem_req_o = (state_q == ST_RD) || (state_q == ST_WR);
   assign mem_we_o  = (state_q == ST_WR);
   assign take_o    = (state_q == ST_WAIT) && req_i;
   assign rd_done_o = (state_q == ST_RD) && mem_ack_i;
   assign wr_done_o = (state_q == ST_WR) && mem_ack_i;
   assign post_o    = (state_q == ST_POST);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_seq_pkg::*;
#(
   parameter int AW          = 24,
   parameter int CW          = 16,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int WORD_STEP   = 2
) (
   input  logic          clk_i,
   input  logic          rst_n_i,
   input  logic          start_i,
   input  logic [CW-1:0] xfer_cnt_i,
   input  logic          size_word_i,
   input  logic [1:0]    act_mode_i,
   input  logic          dst_dir_i,
   input  logic          dst_step_en_i,
   input  logic [AW-1:0] dst_base_i,
   input  logic [AW-1:0] src_addr_i,
   input  logic          dreq_n_i,
   output logic          bus_req_o,
   input  logic          bus_gnt_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ack_i,
   output logic [AW-1:0] dst_addr_o,
   output logic          active_o,
   output logic          done_o
);
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   act_mode_e     mode_q;
   logic          dir_q, step_en_q, size_q;
   logic          active_q, done_q;
   logic [AW-1:0] dst_q, src_q, dst_next;
   logic [CW-1:0] cnt_q;
   logic [DW-1:0] data_q;
   logic          load, req, take, rd_done, wr_done, post, cnt_last, burst;

   assign load     = start_i && !active_q && (xfer_cnt_i != '0);
   assign cnt_last = (cnt_q == CNT_ONE);
   assign burst    = (mode_q == ACT_BURST);

   dma_req_detect #(.SYNC_STAGES(SYNC_STAGES)) u_req (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .dreq_n_i(dreq_n_i),
      .mode_i  (mode_q),
      .arm_i   (active_q),
      .clear_i (load),
      .take_i  (take),
      .req_o   (req)
   );

   dma_addr_step #(.AW(AW), .WORD_STEP(WORD_STEP)) u_step (
      .addr_i     (dst_q),
      .size_word_i(size_q),
      .dir_i      (dir_q),
      .step_en_i  (step_en_q),
      .next_o     (dst_next)
   );

   dma_xfer_fsm u_fsm (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .active_i (active_q),
      .req_i    (req),
      .burst_i  (burst),
      .last_i   (cnt_last),
      .bus_gnt_i(bus_gnt_i),
      .mem_ack_i(mem_ack_i),
      .bus_req_o(bus_req_o),
      .mem_req_o(mem_req_o),
      .mem_we_o (mem_we_o),
      .take_o   (take),
      .rd_done_o(rd_done),
      .wr_done_o(wr_done),
      .post_o   (post)
   );

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         mode_q    <= ACT_EDGE;
         dir_q     <= 1'b0;
         step_en_q <= 1'b0;
         size_q    <= 1'b0;
         active_q  <= 1'b0;
         done_q    <= 1'b0;
         dst_q     <= '0;
         src_q     <= '0;
         cnt_q     <= '0;
         data_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            mode_q    <= act_mode_e'(act_mode_i);
            dir_q     <= dst_dir_i;
            step_en_q <= dst_step_en_i;
            size_q    <= size_word_i;
            dst_q     <= dst_base_i;
            src_q     <= src_addr_i;
            cnt_q     <= xfer_cnt_i;
            active_q  <= 1'b1;
         end
         if (rd_done) data_q <= mem_rdata_i;
         if (post) begin
            dst_q <= dst_next;
            cnt_q <= cnt_q - CNT_ONE;
            if (cnt_last) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
      end
   end

   assign mem_addr_o  = mem_we_o ? dst_q : src_q;
   assign mem_wdata_o = data_q;
   assign dst_addr_o  = dst_q;
   assign active_o    = active_q;
   assign done_o      = done_q;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
   parameter int AW = 24
) (
   input logic          clk_i,
   input logic          rst_n_i,
   input logic          start_i,
   input logic          bus_req_o,
   input logic          bus_gnt_i,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic          mem_ack_i,
   input logic [AW-1:0] dst_addr_o,
   input logic          active_o,
   input logic          done_o,
   input logic          burst,
   input logic          cnt_last,
   input logic          wr_done
);
   localparam logic [AW-1:0] D_P1 = AW'(1);
   localparam logic [AW-1:0] D_P2 = AW'(2);
   localparam logic [AW-1:0] D_M1 = '1;
   localparam logic [AW-1:0] D_M2 = '1 - AW'(1);

   AST_ADDR_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!$stable(dst_addr_o) && !$past(start_i)) |-> $past(mem_req_o && mem_we_o && mem_ack_i, 2)); // R3
   AST_ADDR_STEP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!$stable(dst_addr_o) && !$past(start_i)) |->
         ((AW'(dst_addr_o - $past(dst_addr_o)) == D_P1) || (AW'(dst_addr_o - $past(dst_addr_o)) == D_P2) ||
          (AW'(dst_addr_o - $past(dst_addr_o)) == D_M1) || (AW'(dst_addr_o - $past(dst_addr_o)) == D_M2))); // R2
   AST_STEAL_GAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (wr_done && !burst) |=> ##1 !bus_req_o); // R7
   AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (wr_done && burst && !cnt_last) |=> ##1 bus_req_o); // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_o |=> !done_o); // R9
   AST_DONE_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      done_o |-> !active_o); // R9
   AST_MEM_UNDER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      mem_req_o |-> (bus_req_o && bus_gnt_i)); // R11
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW)) u_chk (
   .clk_i     (clk_i),
   .rst_n_i   (rst_n_i),
   .start_i   (start_i),
   .bus_req_o (bus_req_o),
   .bus_gnt_i (bus_gnt_i),
   .mem_req_o (mem_req_o),
   .mem_we_o  (mem_we_o),
   .mem_ack_i (mem_ack_i),
   .dst_addr_o(dst_addr_o),
   .active_o  (active_o),
   .done_o    (done_o),
   .burst     (burst),
   .cnt_last  (cnt_last),
   .wr_done   (wr_done)
);

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] cnt = '0;
   logic        size_w = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        dir = 1'b0;
   logic        sten = 1'b0;
   logic [23:0] base = '0;
   logic [23:0] src = 24'h00AB12;
   logic        dreq_n = 1'b1;
   logic        bus_req, gnt, mem_req, mem_we, ack, active, done;
   logic [23:0] mem_addr, dst_addr;
   logic [15:0] wdata, rdata;

   int total = 0;
   int bad = 0;
   int wn = 0;
   int falls = 0;
   int dones = 0;
   int rd_bad = 0;
   int data_bad = 0;
   logic        req_prev = 1'b0;
   logic [23:0] waddr [0:63];

   always #10 clk = ~clk;

   dma_xfer_seq uut (
      .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .xfer_cnt_i(cnt),
      .size_word_i(size_w), .act_mode_i(mode), .dst_dir_i(dir),
      .dst_step_en_i(sten), .dst_base_i(base), .src_addr_i(src),
      .dreq_n_i(dreq_n), .bus_req_o(bus_req), .bus_gnt_i(gnt),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ack_i(ack),
      .dst_addr_o(dst_addr), .active_o(active), .done_o(done)
   );

   assign rdata = {mem_addr[7:0], 8'h5A};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack <= 1'b0;
         gnt <= 1'b0;
      end else begin
         ack <= mem_req & ~ack;
         gnt <= bus_req;
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_we && ack) begin
            if (wn < 64) waddr[wn] <= mem_addr;
            if (wdata != {src[7:0], 8'h5A}) data_bad <= data_bad + 1;
            wn <= wn + 1;
         end
         if (mem_req && !mem_we && ack && mem_addr != src) rd_bad <= rd_bad + 1;
         if (req_prev && !bus_req) falls <= falls + 1;
         if (done) dones <= dones + 1;
         req_prev <= bus_req;
      end
   end

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic start_job(input int c, input logic sw, input logic [1:0] m,
                            input logic d, input logic e, input logic [23:0] b);
      @(negedge clk);
      cnt = c[15:0]; size_w = sw; mode = m; dir = d; sten = e; base = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input int d0, input int limit);
      for (int i = 0; i < limit; i++) begin
         if (dones != d0) break;
         @(negedge clk);
      end
      wait_cyc(2);
   endtask

   task automatic t_reset;
      check(bus_req == 0 && mem_req == 0, "R10 bus/mem idle", {bus_req, mem_req}, 0);
      check(active == 0 && done == 0, "R10 active/done", {active, done}, 0);
      check(dst_addr == 0, "R10 dst addr", dst_addr, 0);
   endtask

   task automatic t_burst_inc;
      int w0 = wn, f0 = falls, d0 = dones;
      start_job(4, 0, 2'b11, 0, 1, 24'h000100);
      wait_done(d0, 200);
      check(wn - w0 == 4, "R8 burst write count", wn - w0, 4);
      for (int i = 0; i < 4; i++)
         check(waddr[w0+i] == 24'h100 + i, "R2 inc byte addr", waddr[w0+i], 24'h100 + i);
      check(falls - f0 == 1, "R8 bus held through burst", falls - f0, 1);
      check(dst_addr == 24'h104, "R3 final dst byte", dst_addr, 24'h104);
      check(active == 0, "R9 active cleared", active, 0);
      check(dones - d0 == 1, "R9 single done pulse", dones - d0, 1);
   endtask

   task automatic t_steal_dec;
      int w0 = wn, f0 = falls, d0 = dones;
      start_job(3, 1, 2'b10, 1, 1, 24'h000200);
      wait_done(d0, 200);
      check(wn - w0 == 3, "R7 steal write count", wn - w0, 3);
      for (int i = 0; i < 3; i++)
         check(waddr[w0+i] == 24'h200 - 2*i, "R2 dec word addr", waddr[w0+i], 24'h200 - 2*i);
      check(falls - f0 == 3, "R7 bus released per transfer", falls - f0, 3);
      check(dst_addr == 24'h1FA, "R3 final dst word", dst_addr, 24'h1FA);
   endtask

   task automatic t_hold;
      int w0 = wn, d0 = dones;
      start_job(3, 1, 2'b10, 0, 0, 24'h000300);
      wait_done(d0, 200);
      for (int i = 0; i < 3; i++)
         check(waddr[w0+i] == 24'h300, "R2 hold dir0", waddr[w0+i], 24'h300);
      w0 = wn; d0 = dones;
      start_job(2, 0, 2'b11, 1, 0, 24'h000310);
      wait_done(d0, 200);
      for (int i = 0; i < 2; i++)
         check(waddr[w0+i] == 24'h310, "R2 hold dir1", waddr[w0+i], 24'h310);
      check(dst_addr == 24'h310, "R2 held final", dst_addr, 24'h310);
   endtask

   task automatic t_wrap;
      int w0 = wn, d0 = dones;
      start_job(2, 1, 2'b11, 0, 1, 24'hFFFFFF);
      wait_done(d0, 200);
      check(waddr[w0] == 24'hFFFFFF && waddr[w0+1] == 24'h000001, "R3 wrap up",
            waddr[w0+1], 24'h000001);
      check(dst_addr == 24'h000003, "R3 wrap up final", dst_addr, 24'h000003);
      w0 = wn; d0 = dones;
      start_job(2, 0, 2'b11, 1, 1, 24'h000000);
      wait_done(d0, 200);
      check(waddr[w0+1] == 24'hFFFFFF, "R3 wrap down", waddr[w0+1], 24'hFFFFFF);
      check(dst_addr == 24'hFFFFFE, "R3 wrap down final", dst_addr, 24'hFFFFFE);
   endtask

   task automatic t_edge;
      int w0 = wn, d0 = dones;
      start_job(3, 0, 2'b00, 0, 1, 24'h000400);
      wait_cyc(20);
      check(wn - w0 == 0, "R5 no edge no transfer", wn - w0, 0);
      dreq_n = 1'b0; wait_cyc(2);
      dreq_n = 1'b1; wait_cyc(3);
      dreq_n = 1'b0; wait_cyc(2);
      dreq_n = 1'b1; wait_cyc(60);
      check(wn - w0 == 2, "R5 two edges two transfers", wn - w0, 2);
      check(active == 1, "R5 still active", active, 1);
      dreq_n = 1'b0; wait_cyc(2);
      dreq_n = 1'b1;
      wait_done(d0, 200);
      check(wn - w0 == 3, "R5 third edge completes", wn - w0, 3);
      check(dst_addr == 24'h403, "R5 final dst", dst_addr, 24'h403);
   endtask

   task automatic t_level;
      int w0 = wn, d0 = dones, n;
      start_job(10, 0, 2'b01, 0, 1, 24'h000500);
      wait_cyc(20);
      check(wn - w0 == 0, "R6 pin high no transfer", wn - w0, 0);
      dreq_n = 1'b0;
      for (int i = 0; i < 300; i++) begin
         if (wn - w0 >= 3) break;
         @(negedge clk);
      end
      dreq_n = 1'b1;
      wait_cyc(40);
      n = wn - w0;
      check(n >= 3 && n <= 4, "R6 stops after pin high", n, 4);
      check(active == 1, "R6 active while paused", active, 1);
      start_job(5, 0, 2'b11, 0, 1, 24'h000700);
      wait_cyc(20);
      check(wn - w0 == n, "R1 start while active ignored", wn - w0, n);
      check(dst_addr == 24'h500 + n, "R1 base not reloaded", dst_addr, 24'h500 + n);
      dreq_n = 1'b0;
      wait_done(d0, 1000);
      dreq_n = 1'b1;
      check(wn - w0 == 10, "R6 level completes count", wn - w0, 10);
   endtask

   task automatic t_zero;
      int w0 = wn;
      start_job(0, 0, 2'b11, 0, 1, 24'h000800);
      wait_cyc(10);
      check(active == 0, "R1 zero count ignored", active, 0);
      check(wn - w0 == 0 && dst_addr != 24'h800, "R1 zero count no load", dst_addr, 0);
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait_cyc(3);
      t_reset();
      rst_n = 1'b1;
      wait_cyc(3);
      t_burst_inc();
      t_steal_dec();
      t_hold();
      t_wrap();
      t_edge();
      t_level();
      t_zero();
      check(rd_bad == 0, "R4 reads from fixed source", rd_bad, 0);
      check(data_bad == 0, "R4 write data matches read", data_bad, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule